// File: doc/BRIEF.md
# Multi-port SDRAM command scheduler

This block takes access requests from four master ports and merges them into one SDRAM command stream. Each request names a bank, a row, a column and a direction (read or write). The block remembers which row is open in each bank, chooses among the ports in rotating order and emits at most one command per clock. The command is NOP, PRECHARGE, ACTIVE, READ or WRITE, together with its bank, address and originating port. The data path, refresh and device initialisation sit outside the block.

One accepted request waits in a single commit slot. While a burst from an earlier request is still moving data in one bank, the slot request can close and open a row in another bank. A read to an open row waits until its data lands right after the previous burst, so CAS latency and row-open time are hidden behind the running transfer. Once a port has taken the slot it keeps it until its column command issues. A later request from another port cannot displace it. Each port gets a one-cycle done pulse on the last data beat of its burst.

Top module: `sdram_mp_sched`

## Requirements
- R1: `cmd_o` uses the codes NOP=0, PRECHARGE=1, ACTIVE=2, READ=3, WRITE=4. Only one command is issued per cycle. NOP is driven whenever no request is held in the commit slot, and during reset, when `req_ready_o` and `done_o` are also all zero.
- R2: When the commit slot is empty, `req_ready_o` is one-hot on the first port, in rotating order, that has `req_valid_i` high and no burst outstanding. The search starts at the port after the one last granted, and at port 0 after reset. A grant is accepted in the cycle in which it is shown.
- R3: While a request sits in the commit slot, `req_ready_o` stays zero and every command issued carries that request's port on `cmd_port_o`, until its READ or WRITE issues.
- R4: A PRECHARGE is issued only to a bank whose open row differs from the request's row. An ACTIVE to that bank follows at least TRP cycles after the PRECHARGE.
- R5: An ACTIVE goes only to a closed bank. A READ or WRITE follows at least TRCD cycles after the ACTIVE of its bank.
- R6: A request whose row is already open in its bank gets no PRECHARGE and no ACTIVE.
- R7: A PRECHARGE to a bank is issued only after the last data beat of the previous burst in that bank.
- R8: Data for a READ issued in cycle t occupies cycles t+CL to t+CL+BL-1. Data for a WRITE occupies t+1 to t+BL. Data windows of successive bursts never overlap.
- R9: A read to an open row that is already pending behind a running read issues exactly BL cycles after that read, so the data stream has no gap.
- R10: The PRECHARGE or ACTIVE for the pending request's bank may issue while data of a burst in a different bank is still due.
- R11: `done_o[p]` pulses for one cycle, in the cycle of the last data beat of port p's burst. The port can be granted again from the next cycle.
- R12: ACTIVE carries the request row on `cmd_addr_o`. READ and WRITE carry the column, with WRITE used for a write request and READ for a read request. `cmd_bank_o` carries the request's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NP | Request pending, per port |
| req_bank_i | input | NP x BW | Target bank, per port |
| req_row_i | input | NP x ROW_W | Target row, per port |
| req_col_i | input | NP x COL_W | Start column, per port |
| req_we_i | input | NP | 1 = write, 0 = read, per port |
| req_ready_o | output | NP | One-hot grant; request accepted this cycle |
| done_o | output | NP | Last data beat of the port's burst |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BW | Bank of the command |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row for ACTIVE, column for READ/WRITE |
| cmd_port_o | output | PW | Port the command serves |

## Verification
A done pulse can land in the same cycle as an arbitration decision. In that cycle the finishing port must not yet count as eligible, although its valid may already be high again. The bench provokes this with ports that re-request right after completion while other ports are still queued, both in random traffic and in back-to-back directed bursts. A reference model of the rotation predicts the full ready vector in every cycle. The second collision is a row open in one bank overlapping the data still due from another bank. A timing model of the observed command stream checks it and counts how often it occurs.

// File: rtl/sdsched_pkg.sv
package sdsched_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } sd_cmd_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdsched_rr_arb.sv
module sdsched_rr_arb #(
  parameter int unsigned NP = 4,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NP-1:0] req_i,
  output logic [NP-1:0] gnt_o,
  output logic [PW-1:0] gnt_idx_o
);
  logic [PW-1:0] ptr_q;
  logic [PW:0]   cand;
  logic          found;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    cand      = '0;
    for (int i = 0; i < int'(NP); i++) begin
      cand = {1'b0, ptr_q} + (PW+1)'(i);
      if (cand >= (PW+1)'(NP)) cand = cand - (PW+1)'(NP);
      if (!found && en_i && req_i[cand[PW-1:0]]) begin
        found     = 1'b1;
        gnt_idx_o = cand[PW-1:0];
      end
    end
    if (found) gnt_o[gnt_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found) ptr_q <= (gnt_idx_o == PW'(NP-1)) ? '0 : gnt_idx_o + PW'(1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R2
endmodule

// File: rtl/sdsched_banks.sv
module sdsched_banks import sdsched_pkg::*; #(
  parameter int unsigned NB    = 4,
  parameter int unsigned ROW_W = 13,
  parameter int unsigned CW    = 4,
  parameter int unsigned TRP   = 3,
  parameter int unsigned TRCD  = 3,
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sd_cmd_e          cmd_i,
  input  logic [BW-1:0]    cmd_bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CW-1:0]    busy_span_i,
  input  logic [BW-1:0]    q_bank_i,
  output logic             q_open_o,
  output logic [ROW_W-1:0] q_row_o,
  output logic             q_rp_ok_o,
  output logic             q_rcd_ok_o,
  output logic             q_idle_o
);
  logic [NB-1:0]            open_v, rp_ok_v, rcd_ok_v, idle_v;
  logic [NB-1:0][ROW_W-1:0] row_v;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             sel, open_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    rp_q, rcd_q, busy_q;

    assign sel = (cmd_bank_i == BW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
        rp_q   <= '0;
        rcd_q  <= '0;
        busy_q <= '0;
      end else begin
        if (sel && cmd_i == CMD_PRE) begin
          open_q <= 1'b0;
          rp_q   <= CW'(TRP - 1);
        end else if (rp_q != '0) begin
          rp_q <= rp_q - CW'(1);
        end
        if (sel && cmd_i == CMD_ACT) begin
          open_q <= 1'b1;
          row_q  <= row_i;
          rcd_q  <= CW'(TRCD - 1);
        end else if (rcd_q != '0) begin
          rcd_q <= rcd_q - CW'(1);
        end
        // last beat of the burst in this bank must pass before a close
        if (sel && (cmd_i == CMD_RD || cmd_i == CMD_WR)) busy_q <= busy_span_i;
        else if (busy_q != '0) busy_q <= busy_q - CW'(1);
      end
    end

    assign open_v[b]   = open_q;
    assign row_v[b]    = row_q;
    assign rp_ok_v[b]  = (rp_q == '0);
    assign rcd_ok_v[b] = (rcd_q == '0);
    assign idle_v[b]   = (busy_q == '0);

    AST_ACT_AFTER_TRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && cmd_i == CMD_ACT) |-> (!open_q && rp_q == '0)); // R4
    AST_COL_AFTER_TRCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && (cmd_i == CMD_RD || cmd_i == CMD_WR)) |-> (open_q && rcd_q == '0)); // R5
    AST_PRE_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && cmd_i == CMD_PRE) |-> (busy_q == '0)); // R7
  end

  assign q_open_o   = open_v[q_bank_i];
  assign q_row_o    = row_v[q_bank_i];
  assign q_rp_ok_o  = rp_ok_v[q_bank_i];
  assign q_rcd_ok_o = rcd_ok_v[q_bank_i];
  assign q_idle_o   = idle_v[q_bank_i];
endmodule

// File: rtl/sdsched_ports.sv
module sdsched_ports #(
  parameter int unsigned NP = 4,
  parameter int unsigned CW = 4,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] grant_i,
  input  logic          col_i,
  input  logic [PW-1:0] col_port_i,
  input  logic [CW-1:0] span_i,
  output logic [NP-1:0] busy_o,
  output logic [NP-1:0] done_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          mine;

    assign mine      = col_i && (col_port_i == PW'(p));
    assign done_o[p] = busy_q && (cnt_q == CW'(1));
    assign busy_o[p] = busy_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (grant_i[p]) busy_q <= 1'b1;
        else if (done_o[p]) busy_q <= 1'b0;
        if (mine) cnt_q <= span_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      end
    end

    AST_GNT_IDLE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_i[p] |-> !busy_q); // R11
    AST_COL_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mine |-> (busy_q && cnt_q == '0)); // R3
  end
endmodule

// File: rtl/sdram_mp_sched.sv
module sdram_mp_sched import sdsched_pkg::*; #(
  parameter int unsigned NP    = 4,
  parameter int unsigned NB    = 4,
  parameter int unsigned ROW_W = 13,
  parameter int unsigned COL_W = 10,
  parameter int unsigned TRP   = 3,
  parameter int unsigned TRCD  = 3,
  parameter int unsigned CL    = 3,
  parameter int unsigned BL    = 4,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned AW = max2(ROW_W, COL_W),
  localparam int unsigned CW = $clog2(CL + BL + TRP + TRCD + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NP-1:0]            req_valid_i,
  input  logic [NP-1:0][BW-1:0]    req_bank_i,
  input  logic [NP-1:0][ROW_W-1:0] req_row_i,
  input  logic [NP-1:0][COL_W-1:0] req_col_i,
  input  logic [NP-1:0]            req_we_i,
  output logic [NP-1:0]            req_ready_o,
  output logic [NP-1:0]            done_o,
  output logic [2:0]               cmd_o,
  output logic [BW-1:0]            cmd_bank_o,
  output logic [AW-1:0]            cmd_addr_o,
  output logic [PW-1:0]            cmd_port_o
);
  logic             slot_v_q, slot_we_q;
  logic [PW-1:0]    slot_port_q;
  logic [BW-1:0]    slot_bank_q;
  logic [ROW_W-1:0] slot_row_q;
  logic [COL_W-1:0] slot_col_q;
  logic [CW-1:0]    bus_rem_q, lat, span;
  logic [NP-1:0]    busy, gnt;
  logic [PW-1:0]    gnt_idx;
  logic             q_open, q_rp_ok, q_rcd_ok, q_idle, col_fire;
  logic [ROW_W-1:0] q_row;
  sd_cmd_e          cmd_d;

  sdsched_rr_arb #(.NP(NP)) u_arb (
    .clk_i, .rst_ni,
    .en_i      (!slot_v_q),
    .req_i     (req_valid_i & ~busy),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  assign req_ready_o = gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q    <= 1'b0;
      slot_we_q   <= 1'b0;
      slot_port_q <= '0;
      slot_bank_q <= '0;
      slot_row_q  <= '0;
      slot_col_q  <= '0;
    end else if (|gnt) begin
      slot_v_q    <= 1'b1;
      slot_we_q   <= req_we_i[gnt_idx];
      slot_port_q <= gnt_idx;
      slot_bank_q <= req_bank_i[gnt_idx];
      slot_row_q  <= req_row_i[gnt_idx];
      slot_col_q  <= req_col_i[gnt_idx];
    end else if (col_fire) begin
      slot_v_q <= 1'b0;
    end
  end

  sdsched_banks #(.NB(NB), .ROW_W(ROW_W), .CW(CW), .TRP(TRP), .TRCD(TRCD)) u_banks (
    .clk_i, .rst_ni,
    .cmd_i       (cmd_d),
    .cmd_bank_i  (slot_bank_q),
    .row_i       (slot_row_q),
    .busy_span_i (span),
    .q_bank_i    (slot_bank_q),
    .q_open_o    (q_open),
    .q_row_o     (q_row),
    .q_rp_ok_o   (q_rp_ok),
    .q_rcd_ok_o  (q_rcd_ok),
    .q_idle_o    (q_idle)
  );

  // data starts lat cycles after the column command; last beat at lat+BL-1
  assign lat  = slot_we_q ? CW'(1) : CW'(CL);
  assign span = lat + CW'(BL - 1);

  always_comb begin
    cmd_d = CMD_NOP;
    if (slot_v_q) begin
      if (q_open && q_row == slot_row_q) begin
        // issue so the new data begins right after the running burst
        if (q_rcd_ok && lat >= bus_rem_q) cmd_d = slot_we_q ? CMD_WR : CMD_RD;
      end else if (q_open) begin
        if (q_idle) cmd_d = CMD_PRE;
      end else if (q_rp_ok) begin
        cmd_d = CMD_ACT;
      end
    end
  end

  assign col_fire = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rem_q <= '0;
    else if (col_fire) bus_rem_q <= span;
    else if (bus_rem_q != '0) bus_rem_q <= bus_rem_q - CW'(1);
  end

  sdsched_ports #(.NP(NP), .CW(CW)) u_ports (
    .clk_i, .rst_ni,
    .grant_i    (gnt),
    .col_i      (col_fire),
    .col_port_i (slot_port_q),
    .span_i     (span),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  assign cmd_o      = cmd_d;
  assign cmd_bank_o = (cmd_d == CMD_NOP) ? '0 : slot_bank_q;
  assign cmd_port_o = (cmd_d == CMD_NOP) ? '0 : slot_port_q;
  always_comb begin
    cmd_addr_o = '0;
    if (cmd_d == CMD_ACT) cmd_addr_o = AW'(slot_row_q);
    else if (col_fire)    cmd_addr_o = AW'(slot_col_q);
  end

  AST_NO_READY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_v_q |-> (req_ready_o == '0)); // R3
  AST_SLOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_v_q && !col_fire) |=> (slot_v_q && $stable(slot_port_q) && $stable(slot_bank_q))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R8
  AST_GRANT_CLEARS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_fire |=> !slot_v_q || (|$past(gnt))); // R3
endmodule

// File: tb/tb_sdram_mp_sched.sv
module tb_sdram_mp_sched;
  localparam int NP = 4, NB = 4, ROW_W = 13, COL_W = 10;
  localparam int TRP = 3, TRCD = 3, CL = 3, BL = 4;
  localparam int PW = 2, BW = 2, AW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]            valid = '0, we_in = '0;
  logic [NP-1:0][BW-1:0]    bank_in = '0;
  logic [NP-1:0][ROW_W-1:0] row_in = '0;
  logic [NP-1:0][COL_W-1:0] col_in = '0;
  logic [NP-1:0]            ready, done;
  logic [2:0]               cmd;
  logic [BW-1:0]            cmd_bank;
  logic [AW-1:0]            cmd_addr;
  logic [PW-1:0]            cmd_port;

  sdram_mp_sched dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_bank_i(bank_in), .req_row_i(row_in),
    .req_col_i(col_in), .req_we_i(we_in),
    .req_ready_o(ready), .done_o(done), .cmd_o(cmd),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr), .cmd_port_o(cmd_port)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit ended = 0;

  // reference model of the observed command stream
  logic [NP-1:0] m_busy = '0;
  bit slot_v = 0;
  int slot_p = 0, ptr = 0;
  int rq_bank[NP], rq_row[NP], rq_col[NP], exp_done[NP];
  bit rq_we[NP];
  bit b_open[NB];
  int b_row[NB], t_pre[NB], t_act[NB], b_end[NB];
  int bus_end = -1, bus_bank = -1, overlap_cnt = 0, pa_cnt = 0;
  int rd_prev = -100, rd_last = -100;

  initial begin
    for (int p = 0; p < NP; p++) exp_done[p] = -1;
    for (int b = 0; b < NB; b++) begin
      b_open[b] = 0; b_row[b] = 0; t_pre[b] = -100; t_act[b] = -100; b_end[b] = -1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] rr_exp(logic [NP-1:0] v, logic [NP-1:0] bz, int p0);
    for (int i = 0; i < NP; i++) begin
      int idx;
      idx = (p0 + i) % NP;
      if (v[idx] && !bz[idx]) return NP'(1) << idx;
    end
    return '0;
  endfunction

  always @(negedge clk) begin
    logic [NP-1:0] er;
    int b, lat, st;
    if (!rst_n) begin
      chk(cmd == 0 && ready == 0 && done == 0, "R1", "idle outputs in reset", int'(cmd), 0);
    end else begin
      cyc++;
      er = slot_v ? '0 : rr_exp(valid, m_busy, ptr);
      chk(ready == er, "R2", "ready vector", int'(ready), int'(er));
      b = slot_v ? rq_bank[slot_p] : 0;
      if (cmd != 0) begin
        chk(slot_v, "R1", "command with empty slot", int'(cmd), 0);
        chk(int'(cmd_port) == slot_p, "R3", "command port", int'(cmd_port), slot_p);
        chk(int'(cmd_bank) == b, "R12", "command bank", int'(cmd_bank), b);
      end
      case (cmd)
        3'd0: ;
        3'd1: begin
          pa_cnt++;
          chk(b_open[b] && b_row[b] != rq_row[slot_p], "R4", "precharge on open other row", b_row[b], rq_row[slot_p]);
          chk(cyc > b_end[b], "R7", "precharge after last beat", cyc, b_end[b] + 1);
          if (cyc <= bus_end && bus_bank != b) overlap_cnt++;
          b_open[b] = 0; t_pre[b] = cyc;
        end
        3'd2: begin
          pa_cnt++;
          chk(!b_open[b], "R5", "activate on closed bank", int'(b_open[b]), 0);
          chk(cyc - t_pre[b] >= TRP, "R4", "precharge to activate gap", cyc - t_pre[b], TRP);
          chk(int'(cmd_addr) == rq_row[slot_p], "R12", "activate row", int'(cmd_addr), rq_row[slot_p]);
          if (cyc <= bus_end && bus_bank != b) overlap_cnt++;
          b_open[b] = 1; b_row[b] = rq_row[slot_p]; t_act[b] = cyc;
        end
        3'd3, 3'd4: begin
          chk(b_open[b] && b_row[b] == rq_row[slot_p], "R6", "column on open row", b_row[b], rq_row[slot_p]);
          chk(cyc - t_act[b] >= TRCD, "R5", "activate to column gap", cyc - t_act[b], TRCD);
          chk(int'(cmd_addr) == rq_col[slot_p], "R12", "column address", int'(cmd_addr), rq_col[slot_p]);
          chk((cmd == 3'd4) == rq_we[slot_p], "R12", "direction", int'(cmd), rq_we[slot_p] ? 4 : 3);
          lat = (cmd == 3'd4) ? 1 : CL;
          st = cyc + lat;
          chk(st > bus_end, "R8", "data window overlap", st, bus_end + 1);
          bus_end = st + BL - 1; bus_bank = b; b_end[b] = bus_end;
          exp_done[slot_p] = bus_end;
          if (cmd == 3'd3) begin rd_prev = rd_last; rd_last = cyc; end
          slot_v = 0;
        end
        default: chk(0, "R1", "illegal command code", int'(cmd), 0);
      endcase
      for (int p = 0; p < NP; p++) begin
        chk(done[p] == (cyc == exp_done[p]), "R11", "done pulse", int'(done[p]), int'(cyc == exp_done[p]));
        if (done[p]) m_busy[p] = 0;
      end
      for (int p = 0; p < NP; p++) begin
        if (ready[p] && valid[p]) begin
          m_busy[p] = 1; slot_v = 1; slot_p = p; ptr = (p + 1) % NP;
          rq_bank[p] = int'(bank_in[p]); rq_row[p] = int'(row_in[p]);
          rq_col[p] = int'(col_in[p]); rq_we[p] = we_in[p];
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) if (valid[p] && m_busy[p]) valid[p] = 1'b0;
  endtask

  task automatic put(int p, int bk, int rw, int cl, bit w);
    valid[p] = 1'b1; bank_in[p] = BW'(bk); row_in[p] = ROW_W'(rw);
    col_in[p] = COL_W'(cl); we_in[p] = w;
  endtask

  task automatic wait_idle();
    do step(); while (|valid || |m_busy);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // lowest port first after reset
    put(3, 3, 0, 16, 0); put(1, 1, 5, 8, 0);
    step();
    chk(m_busy == 4'b0010, "R2", "first grant after reset", int'(m_busy), 2);
    wait_idle();
    // gapless read behind read in another open bank
    put(0, 0, 7, 1, 0); put(1, 1, 5, 2, 0);
    wait_idle();
    chk(rd_last - rd_prev == BL, "R9", "read to read spacing", rd_last - rd_prev, BL);
    // same bank, different rows: close waits for the burst
    put(2, 0, 3, 4, 0); put(3, 0, 4, 5, 1);
    wait_idle();
    chk(b_row[0] == 4, "R7", "bank 0 row after conflict", b_row[0], 4);
    // row open in one bank during data of another
    overlap_cnt = 0;
    put(0, 2, 1, 0, 0); put(1, 3, 2, 0, 0);
    wait_idle();
    chk(overlap_cnt > 0, "R10", "overlapped row opens", overlap_cnt, 1);
    // hit needs no precharge or activate
    pa_cnt = 0;
    put(2, 2, 1, 3, 1);
    wait_idle();
    chk(pa_cnt == 0, "R6", "row commands on hit", pa_cnt, 0);
    // commit: later request waits for the held one
    put(3, 1, 9, 6, 0);
    step();
    put(0, 1, 2, 7, 0);
    wait_idle();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step();
      for (int p = 0; p < NP; p++)
        if (!valid[p] && !m_busy[p] && ($urandom % 4) == 0)
          put(p, int'($urandom % NB), int'($urandom % 3), int'($urandom % 1024), bit'($urandom % 2));
    end
    wait_idle();
    repeat (4) step();
    chk(done == '0 && cmd == 0, "R1", "quiet after drain", int'(cmd), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule